// File: doc/BRIEF.md
# Power-On Strap Sampling Sequencer

This block runs the configuration sequence that a clock synthesizer performs after its supply has become stable. Three of the chip's pins do two jobs. During start-up each is an input whose level, set by an external pull resistor, chooses an option. After start-up each becomes a clock output. The sequencer keeps every clock output disabled and every dual-function pin released while those levels settle. It then captures the levels into configuration bits in one cycle. In the next cycle it turns every pin driver and the global output enable on together.

The pins are numbered as follows. Pin index 0 later carries the first reference clock and chooses spread spectrum. Pin index 1 later carries the second reference clock and chooses 48 or 24 MHz for the selectable output. Pin index 2 is the selectable-frequency output itself, and its start-up level chooses between normal operation and a test mode where all outputs stay high-impedance. The captured bits do not change until the next reset. The settle time is a parameter counted in reference-clock cycles. A second parameter holds the start-up budget, which is just under 3 ms at a 14.318 MHz reference.

Top module: `strap_seq`

## Requirements
- R1: While reset is asserted, and for the first SETTLE_CYCLES rising edges after reset is released, `outEn`, all bits of `pinDrive`, `spreadEn`, `sel24` and `hiZMode` are 0.
- R2: The strap levels are taken only from the values present just before rising edge SETTLE_CYCLES+1 after reset release. Levels present at any other time have no effect on the captured bits.
- R3: `spreadEn` equals the captured level of `strapPins[0]`: 1 means spread spectrum on.
- R4: `sel24` equals the captured level of `strapPins[1]`: 0 selects 48 MHz and 1 selects 24 MHz.
- R5: `hiZMode` is the inverse of the captured level of `strapPins[2]`: a low strap selects high-impedance mode (1) and a high strap selects normal operation (0).
- R6: At rising edge SETTLE_CYCLES+1, all three `pinDrive` bits go to 1, the configuration bits take their captured values, and `outEn` goes to 1 unless in high-impedance mode. All of these change at that same edge and never at different edges.
- R7: Once running, the captured bits and the enables stay constant whatever the strap pins do, until reset is asserted. A new reset restarts the whole sequence.
- R8: In high-impedance mode, `outEn` stays 0 after the sequence completes while `pinDrive` is all ones.
- R9: The outputs are live no later than MAX_START_CYCLES edges after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rstN | input | 1 | Asynchronous active-low supply-stable reset |
| strapPins | input | 3 | Levels seen on the dual-function pins: [0] spread, [1] frequency select, [2] high-impedance select |
| spreadEn | output | 1 | Latched spread-spectrum enable |
| sel24 | output | 1 | Latched frequency select, 1 = 24 MHz |
| hiZMode | output | 1 | Latched high-impedance test mode |
| pinDrive | output | 3 | Per-pin direction, 1 = pin driven as a clock output |
| outEn | output | 1 | Global clock output enable |

## Verification
Every result has a fixed cycle. The outputs stay 0 through edge SETTLE_CYCLES. They take their final values at edge SETTLE_CYCLES+1, from the strap levels driven in the half cycle before that edge. They hold from then on, and they fall as soon as reset asserts. For every cycle it drives, the driver queues the output word due at that cycle. The monitor compares one word per cycle at the falling edge, after the registers have settled. The driver puts the complement of the intended strap on the pins in every cycle except the single capture cycle, so a capture in the wrong cycle shows up as a mismatch.

// File: rtl/strap_seq_pkg.sv
package strap_seq_pkg;

  localparam int NUM_DUAL_PINS = 3;
  localparam int PIN_SPREAD    = 0;
  localparam int PIN_FREQSEL   = 1;
  localparam int PIN_HIZ       = 2;

  typedef enum logic [1:0] {
    ST_SETTLE = 2'd0,
    ST_LATCH  = 2'd1,
    ST_RUN    = 2'd2
  } seqState_e;

  typedef struct packed {
    logic latchStb;
  } seqStrobe_t;

endpackage

// File: rtl/strap_seq_ctrl.sv
module strap_seq_ctrl
  import strap_seq_pkg::*;
#(
  parameter int SETTLE_CYCLES    = 32,
  parameter int MAX_START_CYCLES = 42954
) (
  input  logic       clk,
  input  logic       rstN,
  output seqStrobe_t strobe
);

  localparam int CNT_W   = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam int SINCE_W = $clog2(MAX_START_CYCLES + 1);

  seqState_e        state;
  logic [CNT_W-1:0] settleCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_SETTLE;
      settleCnt <= '0;
    end else begin
      case (state)
        ST_SETTLE: begin
          if (settleCnt == CNT_W'(SETTLE_CYCLES - 1)) state <= ST_LATCH;
          else settleCnt <= settleCnt + 1'b1;
        end
        ST_LATCH: state <= ST_RUN;
        default:  state <= ST_RUN;
      endcase
    end
  end

  always_comb strobe.latchStb = (state == ST_LATCH);

  // cycles since reset release, saturating; used only by the checks below
  logic [SINCE_W-1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != SINCE_W'(MAX_START_CYCLES)) sinceRst <= sinceRst + 1'b1;
  end

  a_r2_settle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (int'(sinceRst) < SETTLE_CYCLES) |-> (state == ST_SETTLE));

  a_r6_single_latch: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchStb |=> !strobe.latchStb);

  a_r2_latch_slot: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchStb |-> (int'(sinceRst) == SETTLE_CYCLES));

  a_r9_startup_bound: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == SINCE_W'(MAX_START_CYCLES)) |-> (state == ST_RUN));

endmodule

// File: rtl/strap_seq_dp.sv
module strap_seq_dp
  import strap_seq_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  seqStrobe_t               strobe,
  input  logic [NUM_DUAL_PINS-1:0] strapPins,
  output logic                     spreadEn,
  output logic                     sel24,
  output logic                     hiZMode,
  output logic [NUM_DUAL_PINS-1:0] pinDrive,
  output logic                     outEn
);

  logic spreadQ, selQ, hiZQ, liveQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spreadQ <= 1'b0;
      selQ    <= 1'b0;
      hiZQ    <= 1'b0;
      liveQ   <= 1'b0;
    end else if (strobe.latchStb) begin
      spreadQ <= strapPins[PIN_SPREAD];
      selQ    <= strapPins[PIN_FREQSEL];
      hiZQ    <= ~strapPins[PIN_HIZ];
      liveQ   <= 1'b1;
    end
  end

  always_comb begin
    spreadEn = spreadQ;
    sel24    = selQ;
    hiZMode  = hiZQ;
    pinDrive = {NUM_DUAL_PINS{liveQ}};
    outEn    = liveQ & ~hiZQ;
  end

  a_r6_enable_together: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|pinDrive) |-> ($past(strobe.latchStb) && (&pinDrive)));

  a_r3_spread_capture: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.latchStb) |-> (spreadEn == $past(strapPins[PIN_SPREAD])));

  a_r4_freq_capture: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.latchStb) |-> (sel24 == $past(strapPins[PIN_FREQSEL])));

  a_r5_hiz_capture: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.latchStb) |-> (hiZMode == !$past(strapPins[PIN_HIZ])));

  a_r7_frozen: assert property (@(posedge clk) disable iff (!rstN)
    ($past(&pinDrive) && !strobe.latchStb) |-> $stable({spreadEn, sel24, hiZMode, outEn, pinDrive}));

  a_r8_hiz_gate: assert property (@(posedge clk) disable iff (!rstN)
    hiZMode |-> (!outEn && (&pinDrive)));

  a_r1_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !(|pinDrive) |-> (!outEn && !spreadEn && !sel24 && !hiZMode));

endmodule

// File: rtl/strap_seq.sv
module strap_seq
  import strap_seq_pkg::*;
#(
  parameter int SETTLE_CYCLES    = 32,
  parameter int MAX_START_CYCLES = 42954
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] strapPins,
  output logic       spreadEn,
  output logic       sel24,
  output logic       hiZMode,
  output logic [2:0] pinDrive,
  output logic       outEn
);

  seqStrobe_t strobe;

  strap_seq_ctrl #(
    .SETTLE_CYCLES   (SETTLE_CYCLES),
    .MAX_START_CYCLES(MAX_START_CYCLES)
  ) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe)
  );

  strap_seq_dp dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .strapPins(strapPins),
    .spreadEn (spreadEn),
    .sel24    (sel24),
    .hiZMode  (hiZMode),
    .pinDrive (pinDrive),
    .outEn    (outEn)
  );

endmodule

// File: tb/strap_seq_tb_top.sv
module strap_seq_tb_top;

  localparam int SETTLE    = 32;
  localparam int MAX_START = 42954;

  typedef struct {
    logic [2:0] drv;
    logic       oe;
    logic       ss;
    logic       sel;
    logic       hz;
    string      req;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] strapPins = 3'b000;
  logic       spreadEn, sel24, hiZMode, outEn;
  logic [2:0] pinDrive;

  int checks = 0;
  int fails  = 0;
  expItem_t expQ[$];

  always #5 clk = ~clk;

  strap_seq #(.SETTLE_CYCLES(SETTLE), .MAX_START_CYCLES(MAX_START)) dut_i (
    .clk(clk), .rstN(rstN), .strapPins(strapPins),
    .spreadEn(spreadEn), .sel24(sel24), .hiZMode(hiZMode),
    .pinDrive(pinDrive), .outEn(outEn)
  );

  function automatic expItem_t quietItem(string req);
    expItem_t e;
    e.drv = 3'b000; e.oe = 1'b0; e.ss = 1'b0; e.sel = 1'b0; e.hz = 1'b0; e.req = req;
    return e;
  endfunction

  function automatic expItem_t liveItem(logic [2:0] s, string req);
    expItem_t e;
    e.drv = 3'b111; e.ss = s[0]; e.sel = s[1]; e.hz = ~s[2]; e.oe = s[2]; e.req = req;
    return e;
  endfunction

  // driver: one sequence from reset; the wanted strap sits on the pins only in the capture cycle
  task automatic runSeq(input logic [2:0] finalStrap, input int runCycles);
    @(negedge clk);
    rstN = 1'b0;
    strapPins = finalStrap;
    expQ.push_back(quietItem("R1 reset"));
    @(negedge clk);
    expQ.push_back(quietItem("R1 reset"));
    @(negedge clk);
    rstN = 1'b1;
    strapPins = ~finalStrap;
    expQ.push_back(quietItem("R1 settle"));
    for (int i = 1; i <= SETTLE + runCycles; i++) begin
      @(negedge clk);
      if (i <= SETTLE) expQ.push_back(quietItem("R1/R2 settle"));
      else if (i == SETTLE + 1) expQ.push_back(liveItem(finalStrap, "R6 enable edge R3 R4 R5 R8"));
      else expQ.push_back(liveItem(finalStrap, "R7 frozen"));
      strapPins = (i == SETTLE) ? finalStrap : ~finalStrap;
    end
  endtask

  // monitor: one expected word per falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        checks++;
        if (pinDrive !== e.drv || outEn !== e.oe || spreadEn !== e.ss ||
            sel24 !== e.sel || hiZMode !== e.hz) begin
          fails++;
          $display("FAIL %s: got drv=%b oe=%b ss=%b sel=%b hz=%b, expected drv=%b oe=%b ss=%b sel=%b hz=%b",
                   e.req, pinDrive, outEn, spreadEn, sel24, hiZMode,
                   e.drv, e.oe, e.ss, e.sel, e.hz);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: got hang, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    runSeq(3'b111, 8);   // R3 R4 normal, spread on, 24 MHz
    runSeq(3'b000, 8);   // R5 R8 high-impedance, 48 MHz, spread off
    runSeq(3'b101, 6);   // R4 48 MHz with spread
    runSeq(3'b010, 6);   // R8 hi-z with 24 MHz
    runSeq(3'b100, 3);   // R7 reset mid-run restarts sequence
    runSeq(3'b011, 4);
    @(negedge clk);
    @(negedge clk);
    // R9: the capture edge lies inside the start-up budget
    checks++;
    if (!(SETTLE + 1 <= MAX_START)) begin
      fails++;
      $display("FAIL R9: got start edge %0d, expected at most %0d", SETTLE + 1, MAX_START);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule